// File: doc/BRIEF.md
# Memory-Mapped Terminal I/O Controller

This block is a slave peripheral on a simple 32-bit load/store bus. It presents a keyboard input path and a display output path to a processor as four word-aligned registers at the top of the address space. Each direction has a control register and a data register. The control register holds a device-owned ready flag and a processor-owned interrupt enable.

On the input side, a keyboard source presents a byte with a one-cycle valid strobe. The byte is held until the processor loads it, and that load clears the input ready flag. On the output side, a processor store of a character launches a one-cycle start pulse towards a display sink. Output ready stays low until the sink answers with a done pulse.

A single level interrupt request is raised while either direction is ready with its enable set. Software can therefore use either polling or interrupts.

Top module: `term_mmio_ctrl`

## Requirements
- R1: The registers sit at fixed word addresses: input control 0xFFFF0000, input data 0xFFFF0004, output control 0xFFFF0008, output data 0xFFFF000C. Only exact word-aligned matches select a register.
- R2: A load of either control register returns the ready flag in bit 0, the interrupt enable in bit 1, and zero in bits 31..2.
- R3: A store to a control register with byte lane 0 enabled (bus_be[0]) copies wdata bit 1 into that direction's interrupt enable. The ready flag cannot be changed from the bus.
- R4: A load of the input data register returns the held character in bits 7..0 and zero above. From the next cycle, input ready reads 0, unless R5 applies.
- R5: A kb_valid cycle stores kb_byte and sets input ready from the next cycle, even if the previous byte was never read. When kb_valid coincides with a load of input data, the load returns the older byte and ready stays 1 with the new byte held.
- R6: After reset, output ready is 1, input ready is 0, both enables are 0, the held character is 0, irq is 0 and disp_start is 0.
- R7: A store to output data with byte lane 0 enabled while output ready is 1 produces disp_start high for exactly the next cycle, with disp_byte equal to wdata[7:0]. Output ready reads 0 from that cycle on.
- R8: Output ready returns to 1 in the cycle after a disp_done pulse seen while busy. Stores to output data while busy are ignored (no start pulse, disp_byte unchanged), and disp_done while ready has no effect.
- R9: irq is high exactly while (input ready AND input enable) OR (output ready AND output enable).
- R10: Loads of output data return zero. Accesses to any other address, including misaligned ones and stores to input data, change no state, and loads of such addresses return zero.
- R11: A store to output data or to a control register with byte lane 0 disabled has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 32 | Byte address of the access |
| bus_be | input | 4 | Byte lane enables for stores |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, valid in the same cycle as the request |
| kb_valid | input | 1 | Keyboard byte strobe (one cycle) |
| kb_byte | input | 8 | Keyboard byte |
| disp_start | output | 1 | One-cycle pulse launching a character to the display |
| disp_byte | output | 8 | Character for the display, valid with disp_start |
| disp_done | input | 1 | Display sink finished the previous character |
| irq | output | 1 | Level interrupt request |

## Verification
Two pairs of events can land in the same cycle. On the input side, a keyboard arrival can coincide with the processor's load of the input data register. On the output side, a done pulse from the sink can coincide with a new store to output data. The bench drives both collisions on purpose in directed steps, and drives them again by chance in a long randomized phase. A behavioural model decides each outcome: the arrival wins on the input side, and the store is dropped on the output side because ready was still low in that cycle. The model then compares the returned load data, the ready flags seen through later loads, the start pulse and irq on every clock.

// File: rtl/term_pkg.sv
`timescale 1ns/1ps
package term_pkg;

    localparam int BUS_W   = 32;
    localparam int IDX_W   = 2;
    localparam int OFF_W   = IDX_W + 2;
    localparam int RDY_BIT = 0;
    localparam int IEN_BIT = 1;

    // Word index inside the register window; decoded from address bits [3:2]
    typedef enum logic [IDX_W-1:0] {
        REG_IN_CTL  = 2'd0,
        REG_IN_DAT  = 2'd1,
        REG_OUT_CTL = 2'd2,
        REG_OUT_DAT = 2'd3
    } reg_idx_e;

    typedef enum logic [1:0] {
        OUT_IDLE   = 2'd0,
        OUT_LAUNCH = 2'd1,
        OUT_WAIT   = 2'd2
    } out_state_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        logic     lane0;
        reg_idx_e idx;
    } bus_req_t;

    function automatic logic [BUS_W-1:0] ctl_word(input logic rdy, input logic ien);
        logic [BUS_W-1:0] w;
        w = '0;
        w[RDY_BIT] = rdy;
        w[IEN_BIT] = ien;
        return w;
    endfunction

endpackage

// File: rtl/term_bus_decode.sv
`timescale 1ns/1ps
module term_bus_decode
    import term_pkg::*;
#(
    parameter logic [BUS_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [BUS_W-1:0] bus_addr,
    input  logic [3:0]       bus_be,
    output bus_req_t         req
);
    localparam logic [BUS_W-OFF_W-1:0] WIN_TAG = BASE_ADDR[BUS_W-1:OFF_W];

    logic hit;

    // R1 / R10: only exact word addresses inside the window are claimed
    always_comb begin
        hit       = bus_sel
                 && (bus_addr[BUS_W-1:OFF_W] == WIN_TAG)
                 && (bus_addr[1:0] == 2'b00);
        req.rd    = hit && !bus_we;
        req.wr    = hit && bus_we;
        req.lane0 = bus_be[0];
        req.idx   = reg_idx_e'(bus_addr[OFF_W-1:2]);
    end
endmodule

// File: rtl/term_in_chan.sv
`timescale 1ns/1ps
module term_in_chan #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              kb_valid,
    input  logic [CHAR_W-1:0] kb_byte,
    input  logic              ien_wr,
    input  logic              ien_val,
    input  logic              data_rd,
    output logic              rdy,
    output logic              ien,
    output logic [CHAR_W-1:0] held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdy  <= 1'b0;
            ien  <= 1'b0;
            held <= '0;
        end else begin
            if (ien_wr) ien <= ien_val;            // R3
            if (kb_valid) begin                    // R5: arrival wins
                held <= kb_byte;
                rdy  <= 1'b1;
            end else if (data_rd) begin            // R4
                rdy  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/term_out_chan.sv
`timescale 1ns/1ps
module term_out_chan
    import term_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              store,
    input  logic [CHAR_W-1:0] store_byte,
    input  logic              ien_wr,
    input  logic              ien_val,
    input  logic              disp_done,
    output logic              rdy,
    output logic              ien,
    output logic              disp_start,
    output logic [CHAR_W-1:0] disp_byte
);
    out_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OUT_IDLE:   if (store) st_d = OUT_LAUNCH;   // R7
            OUT_LAUNCH: st_d = OUT_WAIT;
            OUT_WAIT:   if (disp_done) st_d = OUT_IDLE; // R8
            default:    st_d = OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= OUT_IDLE;
            ien       <= 1'b0;
            disp_byte <= '0;
        end else begin
            st_q <= st_d;
            if (ien_wr) ien <= ien_val;
            if (st_q == OUT_IDLE && store) disp_byte <= store_byte;
        end
    end

    assign rdy        = (st_q == OUT_IDLE);
    assign disp_start = (st_q == OUT_LAUNCH);
endmodule

// File: rtl/term_mmio_ctrl.sv
`timescale 1ns/1ps
module term_mmio_ctrl
    import term_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'hFFFF_0000,
    parameter int          CHAR_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [31:0]       bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              kb_valid,
    input  logic [CHAR_W-1:0] kb_byte,
    output logic              disp_start,
    output logic [CHAR_W-1:0] disp_byte,
    input  logic              disp_done,
    output logic              irq
);
    bus_req_t          req;
    logic              in_rdy, in_ien, out_rdy, out_ien;
    logic [CHAR_W-1:0] in_held;

    term_bus_decode #(.BASE_ADDR(BASE_ADDR)) u_dec (
        .bus_sel (bus_sel),
        .bus_we  (bus_we),
        .bus_addr(bus_addr),
        .bus_be  (bus_be),
        .req     (req)
    );

    term_in_chan #(.CHAR_W(CHAR_W)) u_in (
        .clk     (clk),
        .rst     (rst),
        .kb_valid(kb_valid),
        .kb_byte (kb_byte),
        .ien_wr  (req.wr && req.lane0 && req.idx == REG_IN_CTL),   // R3, R11
        .ien_val (bus_wdata[IEN_BIT]),
        .data_rd (req.rd && req.idx == REG_IN_DAT),
        .rdy     (in_rdy),
        .ien     (in_ien),
        .held    (in_held)
    );

    term_out_chan #(.CHAR_W(CHAR_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .store     (req.wr && req.lane0 && req.idx == REG_OUT_DAT), // R7, R11
        .store_byte(bus_wdata[CHAR_W-1:0]),
        .ien_wr    (req.wr && req.lane0 && req.idx == REG_OUT_CTL),
        .ien_val   (bus_wdata[IEN_BIT]),
        .disp_done (disp_done),
        .rdy       (out_rdy),
        .ien       (out_ien),
        .disp_start(disp_start),
        .disp_byte (disp_byte)
    );

    // R2, R4, R10: load data multiplexer
    always_comb begin
        bus_rdata = '0;
        if (req.rd) begin
            unique case (req.idx)
                REG_IN_CTL:  bus_rdata = ctl_word(in_rdy, in_ien);
                REG_IN_DAT:  bus_rdata[CHAR_W-1:0] = in_held;
                REG_OUT_CTL: bus_rdata = ctl_word(out_rdy, out_ien);
                default:     bus_rdata = '0;
            endcase
        end
    end

    // R9
    assign irq = (in_rdy && in_ien) || (out_rdy && out_ien);
endmodule

// File: rtl/term_mmio_sva.sv
`timescale 1ns/1ps
module term_mmio_sva #(
    parameter logic [31:0] BASE_ADDR = 32'hFFFF_0000,
    parameter int          CHAR_W    = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [31:0]       bus_addr,
    input logic [3:0]        bus_be,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              kb_valid,
    input logic [CHAR_W-1:0] kb_byte,
    input logic              disp_start,
    input logic [CHAR_W-1:0] disp_byte,
    input logic              disp_done,
    input logic              irq,
    input logic              in_rdy,
    input logic              in_ien,
    input logic              out_rdy,
    input logic [CHAR_W-1:0] in_held
);
    localparam logic [31:0] A_IN_CTL  = BASE_ADDR;
    localparam logic [31:0] A_IN_DAT  = BASE_ADDR + 32'd4;
    localparam logic [31:0] A_OUT_DAT = BASE_ADDR + 32'd12;

    logic ld_in_dat, st_out_dat, st_in_ctl;
    assign ld_in_dat  = bus_sel && !bus_we && bus_addr == A_IN_DAT;
    assign st_out_dat = bus_sel && bus_we && bus_addr == A_OUT_DAT && bus_be[0];
    assign st_in_ctl  = bus_sel && bus_we && bus_addr == A_IN_CTL && bus_be[0];

    assert_in_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (ld_in_dat && !kb_valid) |=> !in_rdy);

    assert_in_arrival_R5: assert property (@(posedge clk) disable iff (rst)
        kb_valid |=> (in_rdy && in_held == $past(kb_byte)));

    assert_ien_write_R3: assert property (@(posedge clk) disable iff (rst)
        st_in_ctl |=> (in_ien == $past(bus_wdata[1])));

    assert_out_launch_R7: assert property (@(posedge clk) disable iff (rst)
        (st_out_dat && out_rdy) |=> (disp_start && !out_rdy
                                     && disp_byte == $past(bus_wdata[CHAR_W-1:0])));

    assert_start_single_R7: assert property (@(posedge clk) disable iff (rst)
        disp_start |=> !disp_start);

    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!out_rdy && !disp_done) |=> !out_rdy);

    assert_done_ready_R8: assert property (@(posedge clk) disable iff (rst)
        (!out_rdy && !disp_start && disp_done) |=> out_rdy);

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (in_rdy || out_rdy));

    assert_outside_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && bus_addr[31:4] != BASE_ADDR[31:4]) |-> (bus_rdata == 32'd0));
endmodule

bind term_mmio_ctrl term_mmio_sva #(.BASE_ADDR(BASE_ADDR), .CHAR_W(CHAR_W)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .kb_valid  (kb_valid),
    .kb_byte   (kb_byte),
    .disp_start(disp_start),
    .disp_byte (disp_byte),
    .disp_done (disp_done),
    .irq       (irq),
    .in_rdy    (in_rdy),
    .in_ien    (in_ien),
    .out_rdy   (out_rdy),
    .in_held   (in_held)
);

// File: tb/tb_term_mmio_ctrl.sv
`timescale 1ns/1ps
module tb_term_mmio_ctrl;
    localparam logic [31:0] A_IC = 32'hFFFF_0000;
    localparam logic [31:0] A_ID = 32'hFFFF_0004;
    localparam logic [31:0] A_OC = 32'hFFFF_0008;
    localparam logic [31:0] A_OD = 32'hFFFF_000C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [3:0]  bus_be = 4'hF;
    logic [31:0] bus_rdata;
    logic        kb_valid = 1'b0;
    logic [7:0]  kb_byte = '0;
    logic        disp_start;
    logic [7:0]  disp_byte;
    logic        disp_done = 1'b0;
    logic        irq;

    always #2.5 clk = ~clk;

    term_mmio_ctrl dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .kb_valid(kb_valid), .kb_byte(kb_byte),
        .disp_start(disp_start), .disp_byte(disp_byte),
        .disp_done(disp_done), .irq(irq)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R6";

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    // Behavioural reference model
    bit       m_in_rdy, m_in_ien, m_out_ien;
    bit [7:0] m_held, m_dbyte;
    int       m_phase;   // 0 ready, 1 start cycle, 2 waiting for done

    always @(posedge clk) begin
        if (rst) begin
            m_in_rdy <= 0; m_in_ien <= 0; m_out_ien <= 0;
            m_held <= 0; m_dbyte <= 0; m_phase <= 0;
        end else begin
            if (bus_sel && bus_we && bus_be[0] && bus_addr == A_IC) m_in_ien <= bus_wdata[1];
            if (bus_sel && bus_we && bus_be[0] && bus_addr == A_OC) m_out_ien <= bus_wdata[1];
            if (kb_valid) begin
                m_held <= kb_byte; m_in_rdy <= 1;
            end else if (bus_sel && !bus_we && bus_addr == A_ID) m_in_rdy <= 0;
            if (m_phase == 0 && bus_sel && bus_we && bus_be[0] && bus_addr == A_OD) begin
                m_phase <= 1; m_dbyte <= bus_wdata[7:0];
            end else if (m_phase == 1) m_phase <= 2;
            else if (m_phase == 2 && disp_done) m_phase <= 0;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            logic [31:0] exp;
            bit          orr;
            orr = (m_phase == 0);
            check(irq === ((m_in_rdy && m_in_ien) || (orr && m_out_ien)), "R9", "irq",
                  {31'd0, irq}, {31'd0, (m_in_rdy && m_in_ien) || (orr && m_out_ien)});
            check(disp_start === (m_phase == 1), "R7", "disp_start",
                  {31'd0, disp_start}, {31'd0, m_phase == 1});
            if (m_phase == 1)
                check(disp_byte === m_dbyte, "R7", "disp_byte", {24'd0, disp_byte}, {24'd0, m_dbyte});
            if (bus_sel && !bus_we) begin
                if (bus_addr == A_IC)      exp = {30'd0, m_in_ien, m_in_rdy};
                else if (bus_addr == A_ID) exp = {24'd0, m_held};
                else if (bus_addr == A_OC) exp = {30'd0, m_out_ien, orr};
                else                       exp = 32'd0;
                check(bus_rdata === exp, cur_req, "load data", bus_rdata, exp);
            end
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
        bus_sel = 0; bus_we = 0; bus_be = 4'hF; kb_valid = 0; disp_done = 0;
    endtask
    task automatic ld(input logic [31:0] a);
        cyc(); bus_sel = 1; bus_we = 0; bus_addr = a;
    endtask
    task automatic st(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        cyc(); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    endtask
    task automatic key(input logic [7:0] b);
        cyc(); kb_valid = 1; kb_byte = b;
    endtask
    task automatic done_pulse();
        cyc(); disp_done = 1;
    endtask
    task automatic read_all();
        ld(A_IC); ld(A_OC); ld(A_OD);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        cur_req = "R6"; ld(A_IC); ld(A_OC); ld(A_ID);       // reset state
        cur_req = "R1"; ld(A_ID); ld(A_OD);
        cur_req = "R10"; ld(32'hFFFF_0010); ld(32'hFFFF_0002); ld(32'h0000_0000);
        ld(A_OD); st(A_ID, 32'hFF, 4'hF); ld(A_IC);
        cur_req = "R4"; key(8'h41); ld(A_IC); ld(A_ID); ld(A_IC); ld(A_ID);
        cur_req = "R5"; key(8'h10); key(8'h22); ld(A_ID); ld(A_IC);
        // collision: arrival together with a data load
        key(8'h33);
        cyc(); kb_valid = 1; kb_byte = 8'h44; bus_sel = 1; bus_we = 0; bus_addr = A_ID;
        ld(A_IC); ld(A_ID); ld(A_IC);
        cur_req = "R3"; st(A_IC, 32'hFFFF_FFFF, 4'h1); ld(A_IC);
        cur_req = "R9"; key(8'h55); ld(A_IC); ld(A_ID); ld(A_IC);
        cur_req = "R11"; st(A_IC, 32'h0, 4'hE); ld(A_IC);
        st(A_OD, 32'h66, 4'hE); ld(A_OC); cyc();
        cur_req = "R3"; st(A_OC, 32'h2, 4'hF); ld(A_OC);
        cur_req = "R7"; st(A_OD, 32'hABCD_EF5A, 4'hF); ld(A_OC); cyc(); ld(A_OC);
        cur_req = "R8"; st(A_OD, 32'h77, 4'hF); cyc(); cyc(); ld(A_OC);
        done_pulse(); ld(A_OC); done_pulse(); ld(A_OC);
        // collision: done and a store in the same cycle while busy
        st(A_OD, 32'h31, 4'hF); cyc();
        cyc(); disp_done = 1; bus_sel = 1; bus_we = 1; bus_addr = A_OD; bus_wdata = 32'h32;
        ld(A_OC); st(A_OD, 32'h33, 4'hF); cyc(); done_pulse();
        cur_req = "R10"; ld(A_OD); st(32'hFFFF_0011, 32'h2, 4'hF); read_all();
        // randomized phase
        cur_req = "R5";
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            r = $urandom;
            cyc();
            if (r[0]) begin kb_valid = r[1]; kb_byte = r[15:8]; end
            if (r[2]) disp_done = r[3];
            if (r[4] || r[5]) begin
                bus_sel = 1; bus_we = r[6] & r[7];
                bus_be = {3'b111, r[8] | r[9]};
                case (r[12:10])
                    3'd0: bus_addr = A_IC;
                    3'd1, 3'd5: bus_addr = A_ID;
                    3'd2: bus_addr = A_OC;
                    3'd3, 3'd6: bus_addr = A_OD;
                    default: bus_addr = {16'hFFFF, 12'h0, r[16:13]};
                endcase
                bus_wdata = {r[31:24], r[23:16], r[31:24], r[23:16]};
            end
        end
        cyc(); cyc();
        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end
endmodule